// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI bus master controlled through a 32-bit register window with word-aligned byte addresses. Software pushes bytes into a transmit queue, programs the clock idle level, the sampling edge and the bit order, and picks the peripheral by writing an active-low select register directly. A hold bit in the control register keeps the serial clock silent, so a whole burst can be queued before any edge appears. When the hold is released, every queued byte is shifted out back to back, and one received byte is captured into a receive queue for each byte sent.

The serial clock runs at a fixed ratio to the system clock, set by a half-period parameter. A loopback mode sends the outgoing serial data straight into the receive shifter. Each queue can be flushed on its own through self-clearing control bits. Writing one key value to a reset register returns the whole core to its reset state. The interrupt enable and status registers are plain storage.

Top module: `spi_host_mmio`

## Requirements
- R1: After reset the control register reads 0x180 (hold bit 8 and manual-select bit 7 set), the select register reads all ones and drives `ss_n` high on every line, and the status register reads 0x25 (bit0 RX empty, bit2 TX empty, bit5 constant 1).
- R2: The interrupt storage registers read back what was written: offset 0x1C keeps bit 31 only, and offsets 0x20 and 0x28 keep the low IRQ_W bits.
- R3: A write to transmit data (0x68) while status bit3 (TX full) is set is dropped. The occupancy registers (0x74 TX, 0x78 RX) read the entry count minus one.
- R4: While control bit8 (hold) is set, no `sclk` edge is produced even with bytes queued. Clearing it while bit1 (enable) and bit2 (master) are set shifts all queued bytes out.
- R5: Control bit3 sets the `sclk` idle level. With bit4 clear, data is sampled on the leading edge. With bit4 set, it is sampled on the trailing edge.
- R6: With control bit9 clear, the MSB goes first. With bit9 set, the LSB goes first, and the received byte is assembled in the same order.
- R7: With control bit0 (loopback) set, the received byte equals the sent byte whatever `miso` does. With bit0 clear, the bits on `miso` are captured.
- R8: A read of receive data (0x6C) while RX is empty returns zero and leaves the queue unchanged. Status bit1 is set when the RX queue holds RX_DEPTH bytes.
- R9: Status bit2 (TX empty) stays clear until the last queued byte has been fully shifted. By then its received byte is already in the RX queue.
- R10: Control bit5 flushes only the TX queue and bit6 only the RX queue. Both read back as zero, and the other control bits keep the written value.
- R11: Writing 0x0A to offset 0x40 restores every register and empties both queues. Any other value written there changes nothing.
- R12: Bit n of the select register (0x70) drives `ss_n[n]` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low peripheral selects |

## Verification
A register write takes effect at the clock edge that samples it, and read data is registered, so the bench samples `bus_rdata` one full cycle after raising `bus_rd`. A queued byte reaches the wire no earlier than the edge after the hold bit clears. Its received byte enters the RX queue on the same edge as the sixteenth `sclk` transition, which comes 16·HALF_DIV cycles after the start. The bench therefore polls status bit2 rather than counting cycles before it drains the RX queue. A monitor samples `sclk` and `mosi` on falling clock edges, rebuilds each byte according to the programmed edge and bit order, and compares it with the scoreboard queue that the driver fills as it writes bytes.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   // word indices (byte offset >> 2)
   localparam logic [4:0] W_GIE   = 5'd7;   // 0x1C
   localparam logic [4:0] W_ISR   = 5'd8;   // 0x20
   localparam logic [4:0] W_IER   = 5'd10;  // 0x28
   localparam logic [4:0] W_SRST  = 5'd16;  // 0x40
   localparam logic [4:0] W_CTRL  = 5'd24;  // 0x60
   localparam logic [4:0] W_STAT  = 5'd25;  // 0x64
   localparam logic [4:0] W_TXD   = 5'd26;  // 0x68
   localparam logic [4:0] W_RXD   = 5'd27;  // 0x6C
   localparam logic [4:0] W_SEL   = 5'd28;  // 0x70
   localparam logic [4:0] W_TXOCC = 5'd29;  // 0x74
   localparam logic [4:0] W_RXOCC = 5'd30;  // 0x78

   // control bit positions
   localparam int C_LOOP = 0;
   localparam int C_EN   = 1;
   localparam int C_MST  = 2;
   localparam int C_CPOL = 3;
   localparam int C_CPHA = 4;
   localparam int C_TXFL = 5;
   localparam int C_RXFL = 6;
   localparam int C_MSEL = 7;
   localparam int C_HOLD = 8;
   localparam int C_LSB  = 9;

   localparam logic [9:0] CTRL_RST = 10'h180;
   localparam logic [7:0] SRST_KEY = 8'h0A;

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_host_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW:0]   wp_q, rp_q;
   logic          push_ok, pop_ok;

   assign count   = wp_q - rp_q;
   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rp_q[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else if (clr) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp_q[AW-1:0]] <= din;
   end

   // R3: a push into a full queue must not change its occupancy
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (count == $past(count)));

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
   parameter int HALF_DIV = 2,
   localparam int DW      = $clog2(HALF_DIV) + 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       start_ok,
   input  logic [7:0] tx_byte,
   input  logic       cpol,
   input  logic       cpha,
   input  logic       lsb_first,
   input  logic       loopback,
   input  logic       miso,
   output logic       tx_pop,
   output logic       busy,
   output logic       sclk,
   output logic       mosi,
   output logic       rx_push,
   output logic [7:0] rx_byte
);
   import spi_host_pkg::*;

   logic       busy_q, sclk_q, tick, leading, smp, shf, last, rx_bit;
   logic [4:0] edge_q, edge_nx;
   logic [7:0] txsr_q, rxsr_q, rx_nx;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("spi_host_shifter: HALF_DIV must be >= 1");
      end else if (HALF_DIV == 1) begin : g_no_div
         assign tick = busy_q;
      end else begin : g_div
         logic [DW-1:0] div_q;
         assign tick = busy_q && (div_q == DW'(HALF_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 div_q <= '0;
            else if (clr || !busy_q || tick) div_q <= '0;
            else                        div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   assign edge_nx = edge_q + 5'd1;
   assign leading = edge_nx[0];
   assign smp     = tick && (cpha ? !leading : leading);
   assign shf     = tick && (cpha ? (leading && edge_nx != 5'd1)
                                  : (!leading && edge_nx != 5'd16));
   assign last    = tick && (edge_nx == 5'd16);
   assign rx_bit  = loopback ? txsr_q[7] : miso;
   assign rx_nx   = smp ? {rxsr_q[6:0], rx_bit} : rxsr_q;

   assign tx_pop  = !busy_q && start_ok;
   assign rx_push = last;
   assign rx_byte = lsb_first ? rev8(rx_nx) : rx_nx;
   assign busy    = busy_q;
   assign sclk    = busy_q ? sclk_q : cpol;
   assign mosi    = txsr_q[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         edge_q <= '0;
         txsr_q <= '0;
         rxsr_q <= '0;
      end else if (clr) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         edge_q <= '0;
         txsr_q <= '0;
         rxsr_q <= '0;
      end else if (!busy_q) begin
         if (start_ok) begin
            busy_q <= 1'b1;
            sclk_q <= cpol;
            edge_q <= '0;
            txsr_q <= lsb_first ? rev8(tx_byte) : tx_byte;
         end
      end else if (tick) begin
         sclk_q <= ~sclk_q;
         edge_q <= edge_nx;
         rxsr_q <= rx_nx;
         if (shf)  txsr_q <= {txsr_q[6:0], 1'b0};
         if (last) busy_q <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_host_mmio.sv
module spi_host_mmio #(
   parameter int ADDR_W   = 7,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   parameter int NSS      = 4,
   parameter int HALF_DIV = 2,
   parameter int IRQ_W    = 9,
   localparam int TCW     = $clog2(TX_DEPTH) + 1,
   localparam int RCW     = $clog2(RX_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NSS-1:0]    ss_n
);
   import spi_host_pkg::*;

   generate
      if (ADDR_W < 7 || NSS < 1 || NSS > 32 || IRQ_W < 1 || IRQ_W > 32) begin : g_bad_cfg
         $error("spi_host_mmio: unsupported parameter set");
      end
   endgenerate

   logic [9:0]       ctrl_q;
   logic [NSS-1:0]   sel_q;
   logic             gie_q;
   logic [IRQ_W-1:0] isr_q, ier_q;

   logic             aligned, hit_hi;
   logic [4:0]       word;
   logic             wr_w, rd_w, srst;
   logic             tx_push, tx_pop, tx_empty, tx_full, tx_clr;
   logic             rx_push, rx_pop, rx_empty, rx_full, rx_clr;
   logic [7:0]       tx_head, rx_head, rx_byte;
   logic [TCW-1:0]   tx_cnt;
   logic [RCW-1:0]   rx_cnt;
   logic             busy, start_ok;
   logic [31:0]      rd_mux;

   generate
      if (ADDR_W > 7) begin : g_wide
         assign hit_hi = (bus_addr[ADDR_W-1:7] == '0);
      end else begin : g_narrow
         assign hit_hi = 1'b1;
      end
   endgenerate

   assign aligned = (bus_addr[1:0] == 2'b00) && hit_hi;
   assign word    = bus_addr[6:2];
   assign wr_w    = bus_wr && aligned;
   assign rd_w    = bus_rd && aligned;
   assign srst    = wr_w && (word == W_SRST) && (bus_wdata == 32'(SRST_KEY));

   assign tx_push  = wr_w && (word == W_TXD) && !tx_full;
   assign rx_pop   = rd_w && (word == W_RXD) && !rx_empty;
   assign tx_clr   = srst || (wr_w && (word == W_CTRL) && bus_wdata[C_TXFL]);
   assign rx_clr   = srst || (wr_w && (word == W_CTRL) && bus_wdata[C_RXFL]);
   assign start_ok = ctrl_q[C_EN] && ctrl_q[C_MST] && !ctrl_q[C_HOLD] && !tx_empty;

   spi_host_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
      .clk, .rst_n, .clr(tx_clr), .push(tx_push), .din(bus_wdata[7:0]),
      .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full));

   spi_host_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
      .clk, .rst_n, .clr(rx_clr), .push(rx_push), .din(rx_byte),
      .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full));

   spi_host_shifter #(.HALF_DIV(HALF_DIV)) u_shf (
      .clk, .rst_n, .clr(srst), .start_ok,
      .tx_byte(tx_head), .cpol(ctrl_q[C_CPOL]), .cpha(ctrl_q[C_CPHA]),
      .lsb_first(ctrl_q[C_LSB]), .loopback(ctrl_q[C_LOOP]), .miso,
      .tx_pop, .busy, .sclk, .mosi, .rx_push, .rx_byte);

   assign ss_n = sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         sel_q  <= '1;
         gie_q  <= 1'b0;
         isr_q  <= '0;
         ier_q  <= '0;
      end else if (srst) begin
         ctrl_q <= CTRL_RST;
         sel_q  <= '1;
         gie_q  <= 1'b0;
         isr_q  <= '0;
         ier_q  <= '0;
      end else if (wr_w) begin
         case (word)
            W_CTRL: ctrl_q <= bus_wdata[9:0] & ~(10'(1) << C_TXFL) & ~(10'(1) << C_RXFL);
            W_SEL:  sel_q  <= bus_wdata[NSS-1:0];
            W_GIE:  gie_q  <= bus_wdata[31];
            W_ISR:  isr_q  <= bus_wdata[IRQ_W-1:0];
            W_IER:  ier_q  <= bus_wdata[IRQ_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_mux = '0;
      case (word)
         W_GIE:   rd_mux = {gie_q, 31'd0};
         W_ISR:   rd_mux = 32'(isr_q);
         W_IER:   rd_mux = 32'(ier_q);
         W_CTRL:  rd_mux = 32'(ctrl_q);
         W_STAT:  rd_mux = {26'd0, 1'b1, 1'b0, tx_full, tx_empty && !busy, rx_full, rx_empty};
         W_RXD:   rd_mux = rx_empty ? 32'd0 : {24'd0, rx_head};
         W_SEL:   rd_mux = 32'(sel_q);
         W_TXOCC: rd_mux = 32'(TCW'(tx_cnt - 1'b1));
         W_RXOCC: rd_mux = 32'(RCW'(rx_cnt - 1'b1));
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (srst)   bus_rdata <= '0;
      else if (rd_w)   bus_rdata <= rd_mux;
   end

   // R4: with the hold bit set an idle engine must stay idle
   a_r4_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[C_HOLD] && !busy) |=> !busy);

   // R8: reading an empty receive queue yields zero
   a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_w && word == W_RXD && rx_empty && !srst) |=> (bus_rdata == 32'd0));

   // R11: key write restores control and select registers, empties queues
   a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (ctrl_q == CTRL_RST && sel_q == '1 && tx_empty && rx_empty && !busy));

   // R3: a dropped write leaves the TX count only reduced by an engine pop
   a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_w && word == W_TXD && tx_full && !tx_clr)
         |=> (tx_cnt == $past(tx_cnt) - TCW'($past(tx_pop))));

endmodule

// File: tb/spi_host_mmio_tb.sv
module spi_host_mmio_tb;
   localparam int DEPTH = 8;
   localparam int NSS   = 4;
   localparam logic [6:0] A_GIE = 7'h1C, A_ISR = 7'h20, A_IER = 7'h28, A_SRST = 7'h40,
      A_CTRL = 7'h60, A_STAT = 7'h64, A_TXD = 7'h68, A_RXD = 7'h6C, A_SEL = 7'h70,
      A_TXOCC = 7'h74, A_RXOCC = 7'h78;
   localparam logic [9:0] LOOP = 10'h001, EN = 10'h002, MST = 10'h004, CPOL = 10'h008,
      CPHA = 10'h010, TXFL = 10'h020, RXFL = 10'h040, MSEL = 10'h080, HOLD = 10'h100,
      LSB = 10'h200;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [6:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic sclk, mosi, miso;
   logic [NSS-1:0] ss_n;

   always #4 clk = ~clk;   // 125 MHz
   assign miso = ~mosi;    // external peripheral answers with inverted data

   spi_host_mmio #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH), .NSS(NSS)) u_dut (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
      .sclk, .mosi, .miso, .ss_n);

   int n_chk = 0, n_bad = 0;
   logic [7:0] q_wire[$];
   logic [7:0] q_rx[$];
   logic cur_cpol = 0, cur_cpha = 0, cur_lsb = 0, hold_mon = 1;
   int edges = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: rebuild bytes from the wire and compare with the scoreboard
   logic prev_sclk = 0;
   int nbits = 0;
   logic [7:0] acc = 0;
   always @(negedge clk) begin
      if (hold_mon || !rst_n) begin
         prev_sclk <= sclk;
      end else if (sclk !== prev_sclk) begin
         logic lead, take;
         logic [7:0] nx;
         prev_sclk <= sclk;
         edges++;
         lead = (sclk != cur_cpol);
         take = cur_cpha ? !lead : lead;
         if (take) begin
            nx = cur_lsb ? {mosi, acc[7:1]} : {acc[6:0], mosi};
            acc = nx;
            nbits++;
            if (nbits == 8) begin
               nbits = 0;
               if (q_wire.size() == 0) check("R5 unexpected wire byte", {24'd0, nx}, 32'hxxxx_xxxx);
               else check("R5/R6 wire byte", {24'd0, nx}, {24'd0, q_wire.pop_front()});
            end
         end
      end
   end

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_ctrl(input logic [9:0] v);
      hold_mon = 1;
      cur_cpol = v[3]; cur_cpha = v[4]; cur_lsb = v[9];
      wr(A_CTRL, 32'(v));
      @(negedge clk);
      hold_mon = 0;
   endtask

   // driver: queue a byte and its expected wire and receive values
   task automatic put(input logic [7:0] b, input logic loop);
      q_wire.push_back(b);
      q_rx.push_back(loop ? b : ~b);
      wr(A_TXD, 32'(b));
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(A_STAT, s);
         if (s[2]) break;
      end
   endtask

   task automatic drain(input string req, input int n);
      logic [31:0] d;
      for (int i = 0; i < n; i++) begin
         rd(A_RXD, d);
         check(req, d, (q_rx.size() > 0) ? {24'd0, q_rx.pop_front()} : 32'd0);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      logic [9:0] base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, d); check("R1 ctrl reset", d, 32'h180);
      rd(A_STAT, d); check("R1 status reset", d, 32'h25);
      rd(A_SEL, d);  check("R1 select reset", d, 32'hF);
      check("R1 ss_n pins", {28'd0, ss_n}, 32'hF);

      // R2 interrupt storage
      wr(A_GIE, 32'hFFFF_FFFF); rd(A_GIE, d); check("R2 gie", d, 32'h8000_0000);
      wr(A_IER, 32'hFFFF_FFFF); rd(A_IER, d); check("R2 ier", d, 32'h1FF);
      wr(A_ISR, 32'h0000_0155); rd(A_ISR, d); check("R2 isr", d, 32'h155);

      // R12 select lines
      wr(A_SEL, 32'hE); check("R12 ss_n follows register", {28'd0, ss_n}, 32'hE);
      wr(A_SEL, 32'h5); check("R12 ss_n follows register", {28'd0, ss_n}, 32'h5);

      // R4 hold keeps clock quiet with data queued; R3 occupancy
      base = EN | MST | MSEL | LOOP;
      set_ctrl(base | HOLD);
      put(8'hA5, 1); put(8'h3C, 1); put(8'hF0, 1);
      begin : quiet
         int e0;
         e0 = edges;
         repeat (60) @(negedge clk);
         check("R4 no sclk edge while held", 32'(edges), 32'(e0));
      end
      rd(A_TXOCC, d); check("R3 tx occupancy", d, 32'd2);
      rd(A_STAT, d);  check("R4 tx not empty while held", {31'd0, d[2]}, 32'd0);
      set_ctrl(base);
      wait_idle();
      rd(A_RXOCC, d); check("R3 rx occupancy", d, 32'd2);
      drain("R7 loopback rx", 3);
      rd(A_RXD, d); check("R8 empty read zero", d, 32'd0);
      rd(A_STAT, d); check("R8 still empty", {31'd0, d[0]}, 32'd1);

      // R9 tx empty only after the last byte is on the wire
      set_ctrl(base | HOLD);
      put(8'h81, 1);
      set_ctrl(base);
      repeat (6) @(negedge clk);
      rd(A_STAT, d); check("R9 tx empty clear mid byte", {31'd0, d[2]}, 32'd0);
      wait_idle();
      rd(A_STAT, d); check("R9 rx byte present at tx empty", {31'd0, d[0]}, 32'd0);
      drain("R9 rx byte", 1);

      // R5 R6 R7 all clock modes, both orders, loopback and external
      for (int i = 0; i < 8; i++) begin
         logic lp;
         logic [9:0] m;
         lp = i[0] ^ i[2];
         m = EN | MST | MSEL | (i[0] ? CPOL : 10'h0) | (i[1] ? CPHA : 10'h0)
             | (i[2] ? LSB : 10'h0) | (lp ? LOOP : 10'h0);
         set_ctrl(m | HOLD);
         put(8'(8'h13 + 8'(i * 37)), lp);
         put(8'(8'hC1 ^ 8'(i)), lp);
         set_ctrl(m);
         check("R5 sclk idle level", {31'd0, sclk}, {31'd0, cur_cpol});
         wait_idle();
         drain("R7 rx mode sweep", 2);
      end

      // R3 full queue drops the extra write; R8 rx full flag
      set_ctrl(base | HOLD);
      for (int i = 0; i < DEPTH; i++) put(8'(8'h40 + i), 1);
      rd(A_STAT, d); check("R3 tx full flag", {31'd0, d[3]}, 32'd1);
      wr(A_TXD, 32'h0000_00EE);
      rd(A_TXOCC, d); check("R3 extra write dropped", d, 32'(DEPTH - 1));
      set_ctrl(base);
      wait_idle();
      rd(A_STAT, d); check("R8 rx full status", d, 32'h26);
      drain("R3 rx after full burst", DEPTH);
      check("R3 no stray wire byte", 32'(q_wire.size()), 32'd0);

      // R10 independent flushes
      put(8'h99, 1);
      wait_idle();
      set_ctrl(base | HOLD);
      put(8'h11, 1); put(8'h22, 1);
      void'(q_wire.pop_back()); void'(q_wire.pop_back());
      void'(q_rx.pop_back());   void'(q_rx.pop_back());
      set_ctrl(base | HOLD | TXFL);
      rd(A_STAT, d); check("R10 tx flushed rx kept", d[3:0], 32'h4);
      rd(A_CTRL, d); check("R10 ctrl after tx flush", d, 32'(base | HOLD));
      set_ctrl(base | HOLD | RXFL);
      void'(q_rx.pop_front());
      rd(A_STAT, d); check("R10 rx flushed", d[3:0], 32'h5);
      rd(A_CTRL, d); check("R10 ctrl after rx flush", d, 32'(base | HOLD));

      // R11 soft reset key
      wr(A_SEL, 32'h3);
      put(8'h77, 1);
      void'(q_wire.pop_back()); void'(q_rx.pop_back());
      wr(A_SRST, 32'h0000_0005);
      rd(A_CTRL, d); check("R11 wrong key ignored", d, 32'(base | HOLD));
      rd(A_TXOCC, d); check("R11 wrong key keeps tx", d, 32'd0);
      hold_mon = 1;
      wr(A_SRST, 32'h0000_000A);
      cur_cpol = 0; cur_cpha = 0; cur_lsb = 0;
      rd(A_CTRL, d); check("R11 ctrl restored", d, 32'h180);
      rd(A_SEL, d);  check("R11 select restored", d, 32'hF);
      rd(A_STAT, d); check("R11 status restored", d, 32'h25);
      rd(A_IER, d);  check("R11 ier cleared", d, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule